// File: doc/BRIEF.md
# Failureless Parallel-Start Pattern Matcher

This block finds fixed byte patterns in a byte stream. It starts a separate walk through a pattern trie at every byte position, and each walk looks only for patterns that begin at its own start byte. The trie has no failure links. A walk ends on the first byte for which its current state has no outgoing edge. Because every start position gets its own walk, a pattern is found wherever it sits in the stream. No cross-boundary rescanning is needed.

A small pool of walker engines runs in lockstep with the input. Each accepted byte advances every live walker by one edge and may start one new walker in the root state. A walker that reaches a final state reports that state's pattern ID, tagged with its start offset. A walker whose state has no children is retired at once, so its slot can take the new walker in the same cycle. When several matches arise from one byte, they queue up and leave one per cycle, lowest start offset first. The input is held off while they drain.

The trie is stored as an edge list with one entry per non-root state: parent state, edge byte, final flag and pattern ID. So it needs one fewer entry than the state count. Software loads it through a write port before streaming. The pool must have at least L-1 walkers, where L is the longest pattern.

Top module: `pf_matcher`

## Requirements
- R1: While reset is asserted and for two cycles after its release, in_ready is low and match_valid is low; after that, with nothing pending, in_ready is high.
- R2: Every occurrence of a loaded pattern in the accepted byte stream is reported once, with match_start equal to the zero-based count of bytes accepted since reset before its first byte, and match_id equal to the pattern ID stored in its final state.
- R3: Patterns that share a start offset, including one that is a prefix of another, are each reported, in order of increasing length.
- R4: A walk follows only trie edges and ends on the first byte with no edge; no match is reported for any byte sequence that is not exactly a loaded pattern.
- R5: A byte that has no edge out of the root starts no walker and yields no match for its position.
- R6: Matches arising from the same accepted byte are output one per cycle, in ascending start offset; match_start strictly increases across consecutive match_valid cycles.
- R7: With at least L-1 walkers, in_ready is low only while matches are pending or during reset; a byte offered while in_ready is low is not consumed and does not advance the offset.
- R8: A table write with tbl_idx = 0 is ignored (state 0 is the root and has no incoming edge); a write to index k defines the edge parent→k on tbl_char, with its final flag and pattern ID.
- R9: When an accepted byte completes a pattern, match_valid is high in the cycle right after the accepting clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tbl_we | input | 1 | Table write strobe |
| tbl_idx | input | SW | Target state index of the edge being written |
| tbl_parent | input | SW | Parent state of the edge |
| tbl_char | input | 8 | Byte labelling the edge |
| tbl_final | input | 1 | Target state completes a pattern |
| tbl_pid | input | PIDW | Pattern ID reported for the target state |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | Byte accepted on a clock edge where in_valid and in_ready are both high |
| match_valid | output | 1 | A match is presented this cycle |
| match_start | output | 16 | Stream offset of the first byte of the match |
| match_id | output | PIDW | Pattern ID of the match |

## Verification
A walker left in a wrong state shows up within one accepted byte. It either reports a pattern that is not in the stream or loses one that is, and the start offset and ID of each report are compared against a list built independently from the stream. A slot freed too early or reused twice drops or duplicates a match in the same byte's burst. Wrong drain ordering shows up as a swapped pair within a burst of two or more. A stuck pending flag or a lost ready appears at once, as in_ready staying low while match_valid is low.

// File: rtl/pf_pkg.sv
package pf_pkg;
  localparam int unsigned CHAR_W = 8;
  localparam int unsigned OFF_W  = 16;

  typedef logic [OFF_W-1:0]  off_t;
  typedef logic [CHAR_W-1:0] char_t;

  // a started strictly before b, valid while live offsets lie within half the range
  function automatic logic older(input off_t a, input off_t b);
    off_t d;
    d = a - b;
    return d[OFF_W-1];
  endfunction
endpackage

// File: rtl/pf_table.sv
module pf_table
  import pf_pkg::*;
#(
  parameter int NS   = 16,
  parameter int PIDW = 4,
  localparam int SW  = $clog2(NS)
) (
  input  logic                     clk,
  input  logic                     rst_q,
  input  logic                     we,
  input  logic [SW-1:0]            idx,
  input  logic [SW-1:0]            parent,
  input  char_t                    ch,
  input  logic                     fin,
  input  logic [PIDW-1:0]          pid,
  output logic [NS-1:0]            ev_q,
  output logic [NS-1:0][SW-1:0]    par_q,
  output logic [NS-1:0][CHAR_W-1:0] chr_q,
  output logic [NS-1:0]            fin_q,
  output logic [NS-1:0][PIDW-1:0]  pid_q,
  output logic [NS-1:0]            kids
);
  logic wen;
  assign wen = we && (idx != '0);

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      ev_q  <= '0;
      fin_q <= '0;
      par_q <= '0;
      chr_q <= '0;
      pid_q <= '0;
    end else if (wen) begin
      ev_q[idx]  <= 1'b1;
      fin_q[idx] <= fin;
      par_q[idx] <= parent;
      chr_q[idx] <= ch;
      pid_q[idx] <= pid;
    end
  end

  always_comb begin
    kids = '0;
    for (int s = 0; s < NS; s++)
      for (int k = 0; k < NS; k++)
        if (ev_q[k] && par_q[k] == SW'(s)) kids[s] = 1'b1;
  end
endmodule

// File: rtl/pf_lookup.sv
module pf_lookup
  import pf_pkg::*;
#(
  parameter int NS   = 16,
  parameter int PIDW = 4,
  localparam int SW  = $clog2(NS)
) (
  input  logic [SW-1:0]             cur,
  input  char_t                     ch,
  input  logic [NS-1:0]             ev,
  input  logic [NS-1:0][SW-1:0]     par,
  input  logic [NS-1:0][CHAR_W-1:0] chr,
  input  logic [NS-1:0]             fin,
  input  logic [NS-1:0][PIDW-1:0]   pid,
  input  logic [NS-1:0]             kids,
  output logic                      hit,
  output logic [SW-1:0]             nxt,
  output logic                      nfin,
  output logic [PIDW-1:0]           npid,
  output logic                      nleaf
);
  always_comb begin
    hit = 1'b0;
    nxt = '0;
    for (int k = NS - 1; k >= 0; k--)
      if (ev[k] && par[k] == cur && chr[k] == ch) begin
        hit = 1'b1;
        nxt = SW'(k);
      end
    nfin  = hit && fin[nxt];
    npid  = pid[nxt];
    nleaf = !kids[nxt];
  end
endmodule

// File: rtl/pf_pick.sv
module pf_pick
  import pf_pkg::*;
#(
  parameter int NE  = 5,
  localparam int XW = (NE > 1) ? $clog2(NE) : 1
) (
  input  logic [NE-1:0] v,
  input  off_t [NE-1:0] starts,
  output logic          any,
  output logic [XW-1:0] sel
);
  off_t best;
  always_comb begin
    any  = 1'b0;
    sel  = '0;
    best = '0;
    for (int k = 0; k < NE; k++)
      if (v[k] && (!any || older(starts[k], best))) begin
        any  = 1'b1;
        sel  = XW'(k);
        best = starts[k];
      end
  end
endmodule

// File: rtl/pf_matcher.sv
module pf_matcher
  import pf_pkg::*;
#(
  parameter int NW   = 4,
  parameter int NS   = 16,
  parameter int PIDW = 4,
  localparam int SW  = $clog2(NS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tbl_we,
  input  logic [SW-1:0]   tbl_idx,
  input  logic [SW-1:0]   tbl_parent,
  input  logic [7:0]      tbl_char,
  input  logic            tbl_final,
  input  logic [PIDW-1:0] tbl_pid,
  input  logic            in_valid,
  input  logic [7:0]      in_data,
  output logic            in_ready,
  output logic            match_valid,
  output logic [15:0]     match_start,
  output logic [PIDW-1:0] match_id
);
  localparam int NE = NW + 1;
  localparam int FW = (NW > 1) ? $clog2(NW) : 1;
  localparam int XW = (NE > 1) ? $clog2(NE) : 1;

  // reset: asserted at once, released after two edges
  logic rq1, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rq1, rst_q} <= 2'b00;
    else        {rq1, rst_q} <= {1'b1, rq1};
  end

  logic [NS-1:0]             ev, fin, kids;
  logic [NS-1:0][SW-1:0]     par;
  logic [NS-1:0][CHAR_W-1:0] chr;
  logic [NS-1:0][PIDW-1:0]   pid;

  pf_table #(.NS(NS), .PIDW(PIDW)) u_tbl (
    .clk(clk), .rst_q(rst_q), .we(tbl_we), .idx(tbl_idx), .parent(tbl_parent),
    .ch(tbl_char), .fin(tbl_final), .pid(tbl_pid),
    .ev_q(ev), .par_q(par), .chr_q(chr), .fin_q(fin), .pid_q(pid), .kids(kids));

  // walker and pending-match state
  logic [NW-1:0]          act, act_n;
  logic [NW-1:0][SW-1:0]  st, st_n;
  off_t [NW-1:0]          wstart, ws_n;
  logic [NE-1:0]          pv, pv_n;
  off_t [NE-1:0]          pstart, ps_n;
  logic [NE-1:0][PIDW-1:0] ppid, pp_n;
  off_t                   off, off_n;

  logic [NW-1:0]           hit, nfin, leaf, avail;
  logic [NW-1:0][SW-1:0]   nxt;
  logic [NW-1:0][PIDW-1:0] npid;
  logic                    hit_s, fin_s, leaf_s, need_slot, accept, any_p;
  logic [SW-1:0]           nxt_s;
  logic [PIDW-1:0]         pid_s;
  logic [FW-1:0]           fidx;
  logic [XW-1:0]           sel;

  for (genvar i = 0; i < NW; i++) begin : g_walk
    pf_lookup #(.NS(NS), .PIDW(PIDW)) u_lk (
      .cur(st[i]), .ch(in_data), .ev(ev), .par(par), .chr(chr), .fin(fin),
      .pid(pid), .kids(kids), .hit(hit[i]), .nxt(nxt[i]), .nfin(nfin[i]),
      .npid(npid[i]), .nleaf(leaf[i]));
    assign avail[i] = !act[i] || !hit[i] || leaf[i];

    // R4
    walker_root_chk: assert property (@(posedge clk) disable iff (!rst_q)
      act[i] |-> st[i] != '0);
    // R8
    lookup_root_chk: assert property (@(posedge clk) disable iff (!rst_q)
      (act[i] && hit[i]) |-> nxt[i] != '0);
  end

  pf_lookup #(.NS(NS), .PIDW(PIDW)) u_lk_start (
    .cur('0), .ch(in_data), .ev(ev), .par(par), .chr(chr), .fin(fin),
    .pid(pid), .kids(kids), .hit(hit_s), .nxt(nxt_s), .nfin(fin_s),
    .npid(pid_s), .nleaf(leaf_s));

  pf_pick #(.NE(NE)) u_pick (.v(pv), .starts(pstart), .any(any_p), .sel(sel));

  always_comb begin
    fidx = '0;
    for (int i = NW - 1; i >= 0; i--)
      if (avail[i]) fidx = FW'(i);
  end

  assign need_slot = hit_s && !leaf_s;
  assign in_ready  = rst_q && !any_p && (|avail || !need_slot);
  assign accept    = in_valid && in_ready;

  always_comb begin
    act_n = act;   st_n = st;     ws_n = wstart;
    pv_n  = pv;    ps_n = pstart; pp_n = ppid;
    off_n = off;
    if (accept) begin
      off_n = off + 1'b1;
      for (int i = 0; i < NW; i++) begin
        act_n[i] = act[i] && hit[i] && !leaf[i];
        st_n[i]  = nxt[i];
        pv_n[i]  = act[i] && hit[i] && nfin[i];
        ps_n[i]  = wstart[i];
        pp_n[i]  = npid[i];
      end
      pv_n[NW] = fin_s;
      ps_n[NW] = off;
      pp_n[NW] = pid_s;
      if (need_slot) begin
        act_n[fidx] = 1'b1;
        st_n[fidx]  = nxt_s;
        ws_n[fidx]  = off;
      end
    end else if (any_p) begin
      pv_n[sel] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      act <= '0;  st <= '0;     wstart <= '0;
      pv  <= '0;  pstart <= '0; ppid <= '0;
      off <= '0;
    end else if (accept || any_p) begin
      act <= act_n; st <= st_n;     wstart <= ws_n;
      pv  <= pv_n;  pstart <= ps_n; ppid <= pp_n;
      off <= off_n;
    end
  end

  assign match_valid = any_p;
  assign match_start = pstart[sel];
  assign match_id    = ppid[sel];

  // R6
  drain_one_chk: assert property (@(posedge clk) disable iff (!rst_q)
    any_p |=> $countones(pv) == $past($countones(pv)) - 1);
  // R6
  order_up_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (match_valid && $past(match_valid)) |-> older($past(match_start), match_start));
  // R9
  start_hit_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (accept && fin_s) |=> match_valid);
endmodule

// File: tb/sim_pf_matcher.sv
module sim_pf_matcher;
  localparam int CLK_PERIOD = 10;
  localparam int NW = 4, NS = 16, PIDW = 4, SW = 4;

  logic clk, rst_n, tbl_we, tbl_final, in_valid, in_ready, match_valid;
  logic [SW-1:0] tbl_idx, tbl_parent;
  logic [7:0] tbl_char, in_data;
  logic [PIDW-1:0] tbl_pid, match_id;
  logic [15:0] match_start;

  pf_matcher #(.NW(NW), .NS(NS), .PIDW(PIDW)) u0 (
    .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_idx(tbl_idx),
    .tbl_parent(tbl_parent), .tbl_char(tbl_char), .tbl_final(tbl_final),
    .tbl_pid(tbl_pid), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .match_valid(match_valid),
    .match_start(match_start), .match_id(match_id));

  initial begin clk = 1'b0; forever #(CLK_PERIOD/2) clk = ~clk; end

  int n_chk = 0, n_fail = 0;
  string pats[6] = '{"AB", "ABG", "BEDE", "EF", "AAAAA", "DE"};

  logic [7:0] stream[0:511];
  int slen;
  int exp_s[0:511], exp_p[0:511], n_exp;
  bit end_hit[0:511];
  int got_s[0:511], got_p[0:511], n_got;
  bit mon_on = 0;
  int rdy_viol;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  always @(negedge clk) if (mon_on) begin
    if (match_valid) begin
      if (n_got < 512) begin got_s[n_got] = match_start; got_p[n_got] = match_id; end
      n_got++;
    end else if (!in_ready) rdy_viol++;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  function automatic bit match_at(int s, int p);
    for (int j = 0; j < pats[p].len(); j++)
      if (stream[s+j] != pats[p][j]) return 0;
    return 1;
  endfunction

  task automatic compute_exp();
    n_exp = 0;
    for (int e = 0; e < slen; e++) begin
      end_hit[e] = 0;
      for (int s = (e >= 4 ? e - 4 : 0); s <= e; s++)
        for (int p = 0; p < 6; p++)
          if (pats[p].len() == e - s + 1 && match_at(s, p)) begin
            exp_s[n_exp] = s; exp_p[n_exp] = p + 1; n_exp++;
            end_hit[e] = 1;
          end
    end
  endtask

  task automatic wr(input int idx, input int parent, input byte ch,
                    input bit f, input int p);
    tbl_we = 1; tbl_idx = SW'(idx); tbl_parent = SW'(parent);
    tbl_char = ch; tbl_final = f; tbl_pid = PIDW'(p);
    @(negedge clk);
    tbl_we = 0;
  endtask

  task automatic do_reset();
    rst_n = 0; tbl_we = 0; in_valid = 0; in_data = 0;
    tbl_idx = 0; tbl_parent = 0; tbl_char = 0; tbl_final = 0; tbl_pid = 0;
    repeat (3) @(negedge clk);
    chk(in_ready == 0, "R1", "ready in reset", in_ready, 0);
    rst_n = 1;
    @(negedge clk);
    chk(in_ready == 0, "R1", "ready right after release", in_ready, 0);
    repeat (3) @(negedge clk);
    chk(in_ready == 1, "R1", "ready after reset", in_ready, 1);
    chk(match_valid == 0, "R1", "match_valid after reset", match_valid, 0);
    // R8: write to root index must be ignored
    wr(0, 0, "X", 1, 7);
    wr(1, 0, "A", 0, 0);   wr(2, 1, "B", 1, 1);   wr(3, 2, "G", 1, 2);
    wr(4, 0, "B", 0, 0);   wr(5, 4, "E", 0, 0);   wr(6, 5, "D", 0, 0);
    wr(7, 6, "E", 1, 3);   wr(8, 0, "E", 0, 0);   wr(9, 8, "F", 1, 4);
    wr(10, 1, "A", 0, 0);  wr(11, 10, "A", 0, 0); wr(12, 11, "A", 0, 0);
    wr(13, 12, "A", 1, 5); wr(14, 0, "D", 0, 0);  wr(15, 14, "E", 1, 6);
  endtask

  task automatic set_stream(input string s);
    slen = s.len();
    for (int j = 0; j < slen; j++) stream[j] = s[j];
  endtask

  task automatic run(input string req);
    compute_exp();
    n_got = 0; rdy_viol = 0; mon_on = 1;
    for (int e = 0; e < slen; e++) begin
      repeat ($urandom_range(0, 1)) @(negedge clk);
      in_valid = 1; in_data = stream[e];
      forever begin
        #1;
        if (in_ready) begin @(posedge clk); break; end
        @(negedge clk);
      end
      @(negedge clk);
      in_valid = 0;
      if (end_hit[e]) chk(match_valid == 1, "R9", "match_valid after completing byte", match_valid, 1);
    end
    repeat (12) @(negedge clk);
    mon_on = 0;
    chk(n_got == n_exp, req, "match count", n_got, n_exp);
    for (int k = 0; k < n_exp && k < n_got; k++) begin
      chk(got_s[k] == exp_s[k], req, "match start", got_s[k], exp_s[k]);
      chk(got_p[k] == exp_p[k], req, "match id", got_p[k], exp_p[k]);
    end
    chk(rdy_viol == 0, "R7", "ready low with nothing pending", rdy_viol, 0);
  endtask

  initial begin
    void'($urandom(32'd9137));
    do_reset(); set_stream("XABEDEX");   run("R4");
    do_reset(); set_stream("ABGEF");     run("R3");
    do_reset(); set_stream("XXXAB");     run("R5");
    do_reset(); set_stream("AAAAAAAAA"); run("R7");
    do_reset(); set_stream("BEDE");      run("R6");
    do_reset(); set_stream("XXXX");      run("R8");
    do_reset();
    slen = 300;
    for (int j = 0; j < slen; j++) begin
      string alpha;
      alpha = "ABDEFGX";
      stream[j] = alpha[$urandom_range(0, 6)];
    end
    run("R2");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule